// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Cycle Engine

This block runs one SPI flash command cycle at a time on behalf of software. Before a cycle, software loads a menu of eight permitted one-byte opcodes. Each menu entry has a 2-bit type. Software also loads an optional prefix opcode, a 24-bit flash address and up to 64 bytes of write data. It then writes a control word. That word names a menu index, says whether a data phase follows, gives the byte count and sets the go bit. The engine drives chip select low and shifts out the chosen opcode. It sends three address bytes when the entry's type carries an address. It then either shifts out buffer bytes or captures read bytes into the buffer. At the end it raises a done flag.

When the control word asks for an atomic sequence, the prefix opcode (typically a write-enable) goes out first in a chip-select frame of its own. The main cycle follows without a gap in which another request could be accepted. A lock bit, once set, freezes the menu, the type word and the prefix until reset. After that, software can only pick from what was approved. The SPI side runs in mode 0. SCLK is derived from the system clock by a programmable divider.

Register map (word addresses on a 6-bit address):

| Address | Name |
|---|---|
| 0x00 | control |
| 0x01 | status |
| 0x02 | address |
| 0x03 | menu entries 0–3 (entry n in bits 8n+7:8n) |
| 0x04 | menu entries 4–7 |
| 0x05 | type word (entry n in bits 2n+1:2n) |
| 0x06 | prefix opcode |
| 0x07 | lock |
| 0x08 | SCLK half-period divider |
| 0x20–0x2F | data buffer (byte 4w+k in bits 8k+7:8k of word 0x20+w) |

The engine walks through seven named states with the following transitions:

- IDLE leaves on an accepted go. It moves to PREFIX when the atomic bit is set and to OPCODE otherwise.
- PREFIX sends the prefix byte and then moves to SETTLE. SETTLE holds chip select high for the gap and then moves to OPCODE.
- OPCODE moves to ADDR when the type carries an address. Without an address it moves to DATA when data is present, and to TAIL when it is not.
- ADDR sends three bytes and then moves to DATA or TAIL.
- DATA moves bytes until the count is reached and then moves to TAIL.
- TAIL holds chip select high for the gap, raises done and returns to IDLE.

Top module: `opmenu_flash_engine`

## Requirements
- R1: After reset:
  - the status register reads 0;
  - chip select is high and SCLK is low;
  - the lock register reads 0;
  - the divider reads 2.
- R2: Control bits 6:4 select a menu entry, and its opcode is the first byte of the frame. Type bit 1 set means an address follows: bits 23:0 of the address register, most significant byte first, with bits 31:24 ignored.
- R3: For a write type, meaning type bit 0 is set, the data phase sends buffer bytes 0 to N-1 in order. N is control bits 14:8 plus one, and N may be as large as 64.
- R4: For a read type, meaning type bit 0 is clear, the data phase sends 0x00 on MOSI. The bytes received are stored in buffer bytes 0 to N-1 in order, and the other buffer bytes are left unchanged.
- R5: When the data-present bit (control bit 2) is 0, the frame ends after the opcode, or after the address for an address type.
- R6: When control bit 1 is set, the prefix opcode is sent first as a one-byte frame of its own, followed by the main frame.
- R7: Status bit 0 (busy) is high from an accepted go until the cycle ends. Status bit 1 (done) is then set. Writing 1 to status bit 1 or bit 2 clears that bit.
- R8: A go written while busy sets status bit 2 (error) and starts nothing. The running cycle still completes.
- R9: A go with count field 64 or more, which asks for more than 64 bytes, sets the error bit. Nothing is sent and done stays clear.
- R10: Writing 1 to bit 0 of the lock register sets the lock, and nothing but reset clears it. While the lock is set, writes to the menu, the type word and the prefix have no effect.
- R11: The bus runs in mode 0. SCLK is low whenever chip select is high, and MOSI is valid at each rising SCLK edge. Between frames, chip select stays high for at least two SCLK periods, which is 4·div clocks.
- R12: Within a byte, the SCLK period is 2·div system clocks, where div is the divider register. A divider value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
A wrong state register would show on the SPI pins within one byte time as a wrong byte or a wrong frame boundary. The bench's bus monitor catches it on the next byte it assembles. A wrong byte index or a wrong address counter shows up as a mismatch in a single byte, either on MOSI or in the buffer readback right after done. Frame-level mistakes show up at the next chip-select edge:
- a prefix merged into the main frame;
- a gap that is too short;
- a rejected go that still launches a frame.

A lock leak appears at the next register readback.

// File: rtl/flash_engine_pkg.sv
package flash_engine_pkg;
    localparam int MENU_ENTRIES = 8;
    localparam int IDX_W        = 3;

    localparam logic [5:0] A_CTRL    = 6'h00;
    localparam logic [5:0] A_STAT    = 6'h01;
    localparam logic [5:0] A_ADDR    = 6'h02;
    localparam logic [5:0] A_MENU_LO = 6'h03;
    localparam logic [5:0] A_MENU_HI = 6'h04;
    localparam logic [5:0] A_TYPES   = 6'h05;
    localparam logic [5:0] A_PREFIX  = 6'h06;
    localparam logic [5:0] A_LOCK    = 6'h07;
    localparam logic [5:0] A_DIV     = 6'h08;
    localparam logic [5:0] A_BUF     = 6'h20;

    localparam int CTRL_GO     = 0;
    localparam int CTRL_ATOMIC = 1;
    localparam int CTRL_DATA   = 2;
    localparam int CTRL_IDX_LO = 4;
    localparam int CTRL_CNT_LO = 8;

    // type bit 1: address phase present, type bit 0: write direction
    typedef enum logic [2:0] {
        S_IDLE, S_PREFIX, S_SETTLE, S_OPCODE, S_ADDR, S_DATA, S_TAIL
    } cyc_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output logic [7:0]       rx
);
    logic [DIV_W-1:0] cnt;
    logic [7:0]       sh;
    logic [2:0]       bitn;
    logic             active;

    assign mosi = sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            bitn   <= '0;
            active <= 1'b0;
            sclk   <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                sh     <= tx;
                cnt    <= '0;
                bitn   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt == div - 1'b1) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        rx   <= {rx[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/flash_cycle_fsm.sv
module flash_cycle_fsm
    import flash_engine_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int DIV_W     = 8,
    localparam int CNT_W    = $clog2(BUF_BYTES),
    localparam int GAP_W    = DIV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             atomic,
    input  logic             data_en,
    input  logic [1:0]       op_type,
    input  logic [7:0]       opcode,
    input  logic [7:0]       prefix,
    input  logic [23:0]      addr,
    input  logic [CNT_W-1:0] last_idx,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       buf_byte,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    output logic             cs_n,
    output logic             busy,
    output logic             fin,
    output logic             rx_we,
    output logic [CNT_W-1:0] bidx,
    output logic [7:0]       rx_byte
);
    cyc_state_t       state, nxt;
    logic [7:0]       op_l, pre_l;
    logic [23:0]      addr_l;
    logic [CNT_W-1:0] n_l;
    logic             dat_l, wa_l, rd_l, inflight;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_hit;

    assign gap_hit = (gap_cnt == {div, 2'b00} - 1'b1);
    assign busy    = (state != S_IDLE);
    assign rx_byte = sh_rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = atomic ? S_PREFIX : S_OPCODE;
            S_PREFIX: if (sh_done) nxt = S_SETTLE;
            S_SETTLE: if (gap_hit) nxt = S_OPCODE;
            S_OPCODE: if (sh_done) nxt = wa_l ? S_ADDR : (dat_l ? S_DATA : S_TAIL);
            S_ADDR:   if (sh_done && bidx == CNT_W'(2)) nxt = dat_l ? S_DATA : S_TAIL;
            S_DATA:   if (sh_done && bidx == n_l) nxt = S_TAIL;
            S_TAIL:   if (gap_hit) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_comb begin
        cs_n  = 1'b1;
        sh_tx = 8'h00;
        rx_we = 1'b0;
        fin   = 1'b0;
        unique case (state)
            S_PREFIX: begin cs_n = 1'b0; sh_tx = pre_l; end
            S_OPCODE: begin cs_n = 1'b0; sh_tx = op_l; end
            S_ADDR: begin
                cs_n = 1'b0;
                case (bidx[1:0])
                    2'd0:    sh_tx = addr_l[23:16];
                    2'd1:    sh_tx = addr_l[15:8];
                    default: sh_tx = addr_l[7:0];
                endcase
            end
            S_DATA: begin
                cs_n  = 1'b0;
                sh_tx = rd_l ? 8'h00 : buf_byte;
                rx_we = rd_l && sh_done;
            end
            S_TAIL:  fin = gap_hit;
            default: ;
        endcase
        sh_start = !cs_n && !inflight;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_l <= '0; pre_l <= '0; addr_l <= '0; n_l <= '0;
            dat_l <= 1'b0; wa_l <= 1'b0; rd_l <= 1'b0;
            inflight <= 1'b0; bidx <= '0; gap_cnt <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                op_l   <= opcode;
                pre_l  <= prefix;
                addr_l <= addr;
                n_l    <= last_idx;
                dat_l  <= data_en;
                wa_l   <= op_type[1];
                rd_l   <= !op_type[0];
            end
            if (sh_start)     inflight <= 1'b1;
            else if (sh_done) inflight <= 1'b0;
            if (state != nxt) bidx <= '0;
            else if (sh_done && (state == S_ADDR || state == S_DATA)) bidx <= bidx + 1'b1;
            if ((state == S_SETTLE || state == S_TAIL) && state == nxt) gap_cnt <= gap_cnt + 1'b1;
            else gap_cnt <= '0;
        end
    end
endmodule

// File: rtl/opmenu_flash_engine.sv
module opmenu_flash_engine
    import flash_engine_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int DIV_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [5:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam int CNT_W     = $clog2(BUF_BYTES);
    localparam logic [5:0] BUF_END = 6'(A_BUF + BUF_WORDS);

    logic [8*MENU_ENTRIES-1:0] menu_q;
    logic [2*MENU_ENTRIES-1:0] types_q;
    logic [7:0]       prefix_q;
    logic [23:0]      addr_q;
    logic [DIV_W-1:0] div_q, div_eff;
    logic             lock_q, st_done, st_err;
    logic [7:0]       buf_q [BUF_BYTES];

    logic             busy, fin, rx_we, sh_start, sh_done;
    logic [7:0]       sh_tx, sh_rx, rx_byte;
    logic [CNT_W-1:0] bidx;
    logic             ctrl_go, cnt_big, go_ok, go_rej;
    logic [IDX_W-1:0] sel;

    assign div_eff = (div_q == '0) ? DIV_W'(1) : div_q;
    assign sel     = wr_data[CTRL_IDX_LO +: IDX_W];
    assign ctrl_go = wr_en && wr_addr == A_CTRL && wr_data[CTRL_GO];
    assign cnt_big = wr_data[CTRL_CNT_LO +: CNT_W+1] > (CNT_W+1)'(BUF_BYTES-1);
    assign go_ok   = ctrl_go && !busy && !cnt_big;
    assign go_rej  = ctrl_go && (busy || cnt_big);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            menu_q <= '0; types_q <= '0; prefix_q <= '0; addr_q <= '0;
            lock_q <= 1'b0; div_q <= DIV_W'(2); st_done <= 1'b0; st_err <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_STAT: begin
                        if (wr_data[1]) st_done <= 1'b0;
                        if (wr_data[2]) st_err  <= 1'b0;
                    end
                    A_ADDR:    addr_q <= wr_data[23:0];
                    A_MENU_LO: if (!lock_q) menu_q[31:0]  <= wr_data;
                    A_MENU_HI: if (!lock_q) menu_q[63:32] <= wr_data;
                    A_TYPES:   if (!lock_q) types_q <= wr_data[2*MENU_ENTRIES-1:0];
                    A_PREFIX:  if (!lock_q) prefix_q <= wr_data[7:0];
                    A_LOCK:    if (wr_data[0]) lock_q <= 1'b1;
                    A_DIV:     div_q <= wr_data[DIV_W-1:0];
                    default: ;
                endcase
            end
            if (fin)    st_done <= 1'b1;
            if (go_rej) st_err  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rx_we) begin
            buf_q[bidx] <= rx_byte;
        end else if (wr_en && wr_addr >= A_BUF && wr_addr < BUF_END) begin
            for (int k = 0; k < 4; k++)
                buf_q[{wr_addr[WIDX_W-1:0], 2'(k)}] <= wr_data[8*k +: 8];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr >= A_BUF && rd_addr < BUF_END) begin
            for (int k = 0; k < 4; k++)
                rd_data[8*k +: 8] = buf_q[{rd_addr[WIDX_W-1:0], 2'(k)}];
        end else begin
            case (rd_addr)
                A_STAT:    rd_data = {29'd0, st_err, st_done, busy};
                A_ADDR:    rd_data = {8'd0, addr_q};
                A_MENU_LO: rd_data = menu_q[31:0];
                A_MENU_HI: rd_data = menu_q[63:32];
                A_TYPES:   rd_data = 32'(types_q);
                A_PREFIX:  rd_data = {24'd0, prefix_q};
                A_LOCK:    rd_data = {31'd0, lock_q};
                A_DIV:     rd_data = 32'(div_q);
                default:   rd_data = '0;
            endcase
        end
    end

    flash_cycle_fsm #(.BUF_BYTES(BUF_BYTES), .DIV_W(DIV_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(go_ok),
        .atomic(wr_data[CTRL_ATOMIC]), .data_en(wr_data[CTRL_DATA]),
        .op_type(types_q[2*sel +: 2]), .opcode(menu_q[8*sel +: 8]),
        .prefix(prefix_q), .addr(addr_q),
        .last_idx(wr_data[CTRL_CNT_LO +: CNT_W]), .div(div_eff),
        .buf_byte(buf_q[bidx]), .sh_done(sh_done), .sh_rx(sh_rx),
        .sh_start(sh_start), .sh_tx(sh_tx), .cs_n(spi_cs_n), .busy(busy),
        .fin(fin), .rx_we(rx_we), .bidx(bidx), .rx_byte(rx_byte)
    );

    spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .div(div_eff), .start(sh_start), .tx(sh_tx),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
    );
endmodule

// File: rtl/flash_engine_checker.sv
module flash_engine_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        sclk,
    input logic        busy,
    input logic        done_flag,
    input logic        lock_flag,
    input logic [63:0] menu,
    input logic [15:0] types,
    input logic [7:0]  prefix
);
    // R11
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
    // R7
    frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_flag) |-> $past(busy));
    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(lock_flag) |-> lock_flag);
    // R10
    menu_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_flag) |-> ($stable(menu) && $stable(types) && $stable(prefix)));
endmodule

bind opmenu_flash_engine flash_engine_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .busy(busy),
    .done_flag(st_done), .lock_flag(lock_q), .menu(menu_q), .types(types_q),
    .prefix(prefix_q)
);

// File: tb/sim_opmenu_flash_engine.sv
module sim_opmenu_flash_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_chk = 0, n_bad = 0;
    logic [8:0] exp_q[$];

    always #4 clk = ~clk;

    opmenu_flash_engine u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] pat(int p);
        return 8'(p * 37 + 5);
    endfunction
    function automatic logic [7:0] bpat(int i);
        return 8'(i * 3 + 17);
    endfunction
    function automatic logic [31:0] ctl(int idx, int cnt, bit dp, bit at);
        return 32'(((cnt - 1) << 8) | (idx << 4) | (int'(dp) << 2) | (int'(at) << 1) | 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: SPI slave model and scoreboard consumer
    int cyc = 0, p = 0, b = 0, nbit = 0, last_rise = -1, cs_rise_t = -1;
    int min_per = 1000, min_gap = 1000, frames = 0;
    bit first = 1'b0, prev_cs = 1'b1, prev_sclk = 1'b0;
    logic [7:0] shv = '0, tmp;
    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !spi_cs_n) begin
            first = 1'b1; nbit = 0; p = 0; b = 0; last_rise = -1; frames++;
            if (cs_rise_t >= 0 && cyc - cs_rise_t < min_gap) min_gap = cyc - cs_rise_t;
        end
        if (!prev_cs && spi_cs_n) cs_rise_t = cyc;
        if (!spi_cs_n && !prev_sclk && spi_sclk) begin
            if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
            last_rise = cyc;
            shv = {shv[6:0], spi_mosi};
            nbit++;
            if (nbit == 8) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2 unexpected byte actual=%h expected=none", {first, shv});
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    if (e !== {first, shv}) begin
                        n_bad++;
                        $display("FAIL R2/R3 frame byte actual=%h expected=%h", {first, shv}, e);
                    end
                end
                nbit = 0; first = 1'b0;
            end
        end
        if (!spi_cs_n && prev_sclk && !spi_sclk) begin
            b++;
            if (b == 8) begin b = 0; p++; end
        end
        prev_cs = spi_cs_n; prev_sclk = spi_sclk;
        tmp = pat(p);
        spi_miso = tmp[3'(7 - b)];
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask
    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(6'h01, s);
            if (!s[0]) break;
        end
    endtask
    task automatic push(bit f, logic [7:0] v);
        exp_q.push_back({f, v});
    endtask
    task automatic push_addr();
        push(0, 8'h12); push(0, 8'h34); push(0, 8'h56);
    endtask
    task automatic fill_buf();
        for (int w = 0; w < 16; w++)
            wr(6'(32 + w), {bpat(4*w+3), bpat(4*w+2), bpat(4*w+1), bpat(4*w)});
    endtask
    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        rd(6'h01, r); check("R1 status", r, 0);
        check("R1 cs_n", 32'(spi_cs_n), 1);
        check("R1 sclk", 32'(spi_sclk), 0);
        rd(6'h07, r); check("R1 lock", r, 0);
        rd(6'h08, r); check("R1 div", r, 2);

        wr(6'h03, 32'h9F020603);
        wr(6'h04, 32'hC7D82005);
        wr(6'h05, 32'h00000C36);
        wr(6'h02, 32'hAB123456);
        fill_buf();

        // R2 R3: write with address, entry 2, five bytes
        push(1, 8'h02); push_addr();
        for (int i = 0; i < 5; i++) push(0, bpat(i));
        wr(6'h00, ctl(2, 5, 1, 0));
        rd(6'h01, r); check("R7 busy", r, 1);
        wait_idle();
        rd(6'h01, r); check("R7 done", r, 2);
        check("R2 queue drained", 32'(exp_q.size()), 0);
        wr(6'h01, 32'h6);
        rd(6'h01, r); check("R7 w1c", r, 0);

        // R4: read with address, six bytes
        push(1, 8'h03); push_addr();
        for (int i = 0; i < 6; i++) push(0, 8'h00);
        wr(6'h00, ctl(0, 6, 1, 0));
        wait_idle();
        rd(6'h20, r); check("R4 word0", r, {pat(7), pat(6), pat(5), pat(4)});
        rd(6'h21, r); check("R4 word1", r, {bpat(7), bpat(6), pat(9), pat(8)});
        wr(6'h01, 32'h6);

        // R4: read without address, three bytes
        push(1, 8'h9F); push(0, 0); push(0, 0); push(0, 0);
        wr(6'h00, ctl(3, 3, 1, 0));
        wait_idle();
        rd(6'h20, r); check("R4 noaddr word0", r, {pat(7), pat(3), pat(2), pat(1)});

        // R5: no data phase, with and without address
        push(1, 8'h06);
        wr(6'h00, ctl(1, 1, 0, 0));
        wait_idle();
        push(1, 8'h02); push_addr();
        wr(6'h00, ctl(2, 4, 0, 0));
        wait_idle();
        check("R5 queue drained", 32'(exp_q.size()), 0);

        // R6 R11: atomic prefix frame, gap
        wr(6'h06, 32'h06);
        wr(6'h20, 32'h44332211);
        min_gap = 1000;
        push(1, 8'h06); push(1, 8'h02); push_addr(); push(0, 8'h11); push(0, 8'h22);
        wr(6'h00, ctl(2, 2, 1, 1));
        wait_idle();
        check("R6 queue drained", 32'(exp_q.size()), 0);
        check("R11 gap>=8", 32'(min_gap >= 8), 1);
        wr(6'h01, 32'h6);

        // R8 R3: 64-byte write, go while busy
        fill_buf();
        push(1, 8'h02); push_addr();
        for (int i = 0; i < 64; i++) push(0, bpat(i));
        wr(6'h00, ctl(2, 64, 1, 0));
        repeat (40) @(negedge clk);
        wr(6'h00, ctl(1, 1, 0, 0));
        rd(6'h01, r); check("R8 error while busy", r, 5);
        wait_idle();
        rd(6'h01, r); check("R8 status after", r, 6);
        check("R3 64 bytes drained", 32'(exp_q.size()), 0);
        wr(6'h01, 32'h6);

        // R9: count 65 rejected
        frames = 0;
        wr(6'h00, ctl(2, 65, 1, 0));
        repeat (50) @(negedge clk);
        rd(6'h01, r); check("R9 error only", r, 4);
        check("R9 no frame", 32'(frames), 0);
        wr(6'h01, 32'h6);

        // R12: divider 3
        wr(6'h08, 32'h3);
        min_per = 1000;
        push(1, 8'h9F); push(0, 0);
        wr(6'h00, ctl(3, 1, 1, 0));
        wait_idle();
        check("R12 period", 32'(min_per), 6);
        wr(6'h08, 32'h2);

        // R10: lock
        wr(6'h07, 32'h1);
        wr(6'h03, 32'h0);
        wr(6'h05, 32'h0);
        wr(6'h06, 32'hFF);
        wr(6'h07, 32'h0);
        rd(6'h03, r); check("R10 menu frozen", r, 32'h9F020603);
        rd(6'h05, r); check("R10 types frozen", r, 32'h0C36);
        rd(6'h06, r); check("R10 prefix frozen", r, 32'h06);
        rd(6'h07, r); check("R10 lock sticks", r, 1);
        push(1, 8'h06);
        wr(6'h00, ctl(1, 1, 0, 0));
        wait_idle();
        check("R10 menu used", 32'(exp_q.size()), 0);
        repeat (10) @(negedge clk);
        report();
    end
endmodule